// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block holds a byte-wide file of 256 configuration entries behind a two-byte I/O window. Software selects an entry by writing its number to the lower window address. It then reads the entry, or writes it, through the upper address. A read at either address returns the entry that the current index selects.

Most entries are read-only. A data write to one of them is dropped without any side effect. Two entries are keyed: each accepts only one exact byte value and drops any other. The window responds only while an external enable bit is high. While that bit is low, reads return all ones and writes have no effect. Reset loads a small fixed set of default values.

The bus is synchronous and carries single bytes. Read data appears on the output one clock after the read strobe and holds until the next read.

Top module: `idx_cfg_port`

## Requirements
- R1: After reset the index is 0x00 and `rdata_o` is 0x00. Entries 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE. Every other entry holds 0x00.
- R2: While enabled, a write at BASE_ADDR (default 0x03F0) loads `wdata_i` into the index.
- R3: While enabled, a read at BASE_ADDR or BASE_ADDR+1 puts the entry selected by the index on `rdata_o` one cycle later. With no read, `rdata_o` holds its value.
- R4: While enabled, a write at BASE_ADDR+1 stores `wdata_i` into the selected entry if that entry is writable. The writable entries are 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC.
- R5: A data write is dropped, leaving the entry unchanged, when the index is below 0xE0 or is one of 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R6: Entry 0xE7 accepts a data write only when the value is 0xFE. Entry 0xE8 accepts one only when the value is 0xBE. Any other value leaves the entry unchanged.
- R7: While `win_en_i` is low, a read at either window address returns 0xFF, and writes change neither the index nor any entry.
- R8: Accesses at addresses outside the two-byte window change neither the index, nor any entry, nor `rdata_o`.
- R9: A read in the same cycle as a write returns the state from before the write. This covers both a data write and an index write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_en_i | input | 1 | Window enable, taken from the external bridge configuration bit |
| addr_i | input | ADDR_W | I/O address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid one cycle after `rd_i` |

## Verification
A read and a write can land in the same cycle: either a data write at the upper address or an index write at the lower one. The bench drives both strobes together. It first drives them at the data address on a writable entry, then at the index address. It expects the returned byte to be the entry's old value, or the entry at the old index. A follow-up read then confirms that the write did take effect.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int unsigned IDX_W = 8;
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = 1 << IDX_W;

  localparam logic [DW-1:0] KEY_E7 = 8'hFE;
  localparam logic [DW-1:0] KEY_E8 = 8'hBE;
  localparam logic [DW-1:0] OFF_RD = 8'hFF;

  function automatic logic [DW-1:0] reset_val(input logic [IDX_W-1:0] idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return KEY_E7;
      8'hE8:   return KEY_E8;
      default: return '0;
    endcase
  endfunction

  function automatic logic wr_ok(input logic [IDX_W-1:0] idx, input logic [DW-1:0] d);
    if (idx < 8'hE0) return 1'b0;
    case (idx)
      8'hE4, 8'hE5, 8'hE9, 8'hEA, 8'hEB, 8'hEC, 8'hED,
      8'hF3, 8'hF5, 8'hF7, 8'hF9, 8'hFA, 8'hFB,
      8'hFD, 8'hFE, 8'hFF: return 1'b0;
      8'hE7:   return d == KEY_E7;
      8'hE8:   return d == KEY_E8;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/cfg_win_decode.sv
module cfg_win_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic              idx_wr_o,
  output logic              dat_wr_o,
  output logic              rd_on_o,
  output logic              rd_off_o
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR + 1'b1;

  logic at_idx, at_dat, in_win;

  assign at_idx   = (addr_i == BASE_ADDR);
  assign at_dat   = (addr_i == DAT_ADDR);
  assign in_win   = at_idx | at_dat;
  assign idx_wr_o = en_i & wr_i & at_idx;
  assign dat_wr_o = en_i & wr_i & at_dat;
  assign rd_on_o  = en_i & rd_i & in_win;
  assign rd_off_o = ~en_i & rd_i & in_win;
endmodule

// File: rtl/cfg_wr_filter.sv
module cfg_wr_filter
  import cfg_port_pkg::*;
(
  input  logic             req_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    data_i,
  output logic             commit_o
);
  assign commit_o = req_i & wr_ok(idx_i, data_i);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_port_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [DW-1:0]    rdata_o
);
  logic [DW-1:0] mem     [DEPTH];
  logic [DW-1:0] rst_tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rst
    assign rst_tbl[g] = reset_val(IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= rst_tbl[i];
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/idx_cfg_port.sv
module idx_cfg_port
  import cfg_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o
);
  logic             idx_wr, dat_wr, rd_on, rd_off, commit;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    sel_data, rdata_q;

  cfg_win_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .en_i    (win_en_i),
    .addr_i  (addr_i),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .idx_wr_o(idx_wr),
    .dat_wr_o(dat_wr),
    .rd_on_o (rd_on),
    .rd_off_o(rd_off)
  );

  cfg_wr_filter u_flt (
    .req_i   (dat_wr),
    .idx_i   (idx_q),
    .data_i  (wdata_i),
    .commit_o(commit)
  );

  cfg_regfile u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (commit),
    .waddr_i(idx_q),
    .wdata_i(wdata_i),
    .raddr_i(idx_q),
    .rdata_o(sel_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_wr) idx_q <= wdata_i[IDX_W-1:0];
  end

  // read samples pre-edge state, so a same-cycle write is not visible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_on)  rdata_q <= sel_data;
    else if (rd_off) rdata_q <= OFF_RD;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/idx_cfg_port_chk.sv
module idx_cfg_port_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              win_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [7:0]        wdata_i,
  input logic [7:0]        rdata_o,
  input logic [7:0]        idx_q,
  input logic [7:0]        sel_data
);
  localparam logic [ADDR_W-1:0] DAT_ADDR = BASE_ADDR + 1'b1;
  logic in_win;
  assign in_win = (addr_i == BASE_ADDR) || (addr_i == DAT_ADDR);

  // R2
  idx_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_en_i && wr_i && addr_i == BASE_ADDR |=> idx_q == $past(wdata_i));

  // R7
  off_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_i |=> $stable(idx_q));

  // R7
  off_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_i && rd_i && in_win |=> rdata_o == 8'hFF);

  // R3
  read_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_en_i && rd_i && in_win |=> rdata_o == $past(sel_data));

  // R3
  read_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  // R5
  prot_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_en_i && wr_i && addr_i == DAT_ADDR && idx_q < 8'hE0 |=> $stable(sel_data));

  // R6
  key_e7_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_en_i && wr_i && addr_i == DAT_ADDR && idx_q == 8'hE7 && wdata_i != 8'hFE
    |=> sel_data == 8'hFE);

  // R8
  outside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_win |=> $stable(idx_q) && $stable(rdata_o));
endmodule

bind idx_cfg_port idx_cfg_port_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .win_en_i(win_en_i),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .rd_i    (rd_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .idx_q   (idx_q),
  .sel_data(sel_data)
);

// File: tb/sim_idx_cfg_port.sv
`timescale 1ns/1ps
module sim_idx_cfg_port;
  localparam logic [15:0] IA = 16'h03F0;
  localparam logic [15:0] DA = 16'h03F1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        win_en_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  idx_cfg_port u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .win_en_i(win_en_i), .addr_i(addr_i),
    .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one bus cycle; returns rdata_o after the capturing edge
  task automatic op(input logic [15:0] a, input logic w, input logic r,
                    input logic [7:0] d, output logic [7:0] q);
    @(negedge clk_i);
    addr_i = a; wr_i = w; rd_i = r; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0; rd_i = 1'b0;
    q = rdata_o;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] q;
    op(a, 1'b1, 1'b0, d, q);
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] q);
    op(a, 1'b0, 1'b1, 8'h00, q);
  endtask

  task automatic entry(input logic [7:0] idx, output logic [7:0] q);
    wr(IA, idx);
    rd(DA, q);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    chk("R1 rdata after reset", rdata_o, 8'h00);
    win_en_i = 1'b1;
    rd(DA, q);  chk("R1 index resets to 00", q, 8'h00);
    entry(8'hE0, q); chk("R1 E0", q, 8'h3C);
    entry(8'hE1, q); chk("R1 E1", q, 8'h00);
    entry(8'hE2, q); chk("R1 E2", q, 8'h03);
    entry(8'hE3, q); chk("R1 E3", q, 8'hFC);
    entry(8'hE6, q); chk("R1 E6", q, 8'hDE);
    entry(8'hE7, q); chk("R1 E7", q, 8'hFE);
    entry(8'hE8, q); chk("R1 E8", q, 8'hBE);
    entry(8'hF4, q); chk("R1 F4", q, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] q;
    wr(IA, 8'hE3);
    rd(IA, q); chk("R2 R3 read at index address", q, 8'hFC);
    rd(DA, q); chk("R3 read at data address", q, 8'hFC);
    @(negedge clk_i); @(negedge clk_i);
    chk("R3 rdata holds without read", rdata_o, 8'hFC);
  endtask

  task automatic t_write();
    logic [7:0] q;
    wr(IA, 8'hF4); wr(DA, 8'h5A); rd(DA, q); chk("R4 F4 write", q, 8'h5A);
    wr(IA, 8'hEE); wr(DA, 8'hA5); rd(DA, q); chk("R4 EE write", q, 8'hA5);
    wr(IA, 8'hE0); wr(DA, 8'h81); rd(DA, q); chk("R4 E0 write", q, 8'h81);
    wr(IA, 8'hFC); wr(DA, 8'h33); rd(DA, q); chk("R4 FC write", q, 8'h33);
  endtask

  task automatic t_protect();
    logic [7:0] q;
    wr(IA, 8'h10); wr(DA, 8'h77); rd(DA, q); chk("R5 index 10", q, 8'h00);
    wr(IA, 8'hDF); wr(DA, 8'h77); rd(DA, q); chk("R5 index DF", q, 8'h00);
    wr(IA, 8'hE4); wr(DA, 8'h77); rd(DA, q); chk("R5 index E4", q, 8'h00);
    wr(IA, 8'hEB); wr(DA, 8'h77); rd(DA, q); chk("R5 index EB", q, 8'h00);
    wr(IA, 8'hF3); wr(DA, 8'h77); rd(DA, q); chk("R5 index F3", q, 8'h00);
    wr(IA, 8'hFF); wr(DA, 8'h77); rd(DA, q); chk("R5 index FF", q, 8'h00);
  endtask

  task automatic t_keyed();
    logic [7:0] q;
    wr(IA, 8'hE7); wr(DA, 8'h00); rd(DA, q); chk("R6 E7 wrong key", q, 8'hFE);
    wr(DA, 8'hFE); rd(DA, q); chk("R6 E7 right key", q, 8'hFE);
    wr(IA, 8'hE8); wr(DA, 8'h12); rd(DA, q); chk("R6 E8 wrong key", q, 8'hBE);
    wr(DA, 8'hFE); rd(DA, q); chk("R6 E8 E7 key rejected", q, 8'hBE);
  endtask

  task automatic t_disabled();
    logic [7:0] q;
    wr(IA, 8'hF4);
    win_en_i = 1'b0;
    rd(DA, q); chk("R7 disabled read data", q, 8'hFF);
    rd(IA, q); chk("R7 disabled read index", q, 8'hFF);
    wr(IA, 8'hEE);
    wr(DA, 8'h99);
    win_en_i = 1'b1;
    rd(DA, q); chk("R7 index untouched", q, 8'h5A);
  endtask

  task automatic t_outside();
    logic [7:0] q;
    wr(16'h03F2, 8'hEE);
    wr(16'h02F1, 8'h44);
    rd(DA, q); chk("R8 index and entry untouched", q, 8'h5A);
    rd(16'h03F8, q); chk("R8 rdata unchanged by outside read", q, 8'h5A);
  endtask

  task automatic t_collide();
    logic [7:0] q;
    op(DA, 1'b1, 1'b1, 8'h66, q); chk("R9 read sees old data", q, 8'h5A);
    rd(DA, q); chk("R9 write landed", q, 8'h66);
    op(IA, 1'b1, 1'b1, 8'hE6, q); chk("R9 read sees old index", q, 8'h66);
    rd(DA, q); chk("R9 index landed", q, 8'hDE);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_index();
    t_write();
    t_protect();
    t_keyed();
    t_disabled();
    t_outside();
    t_collide();
    finish_run();
  end
endmodule